// File: doc/BRIEF.md
# Trailing bit mask unit

This is a 32-bit datapath block. It runs one of nine operations that act on the lowest set bit or the lowest clear bit of an operand. Each operation is a single AND, OR or XOR of two terms. The terms are drawn from the operand, its complement, the operand plus one and the operand minus one, and both of the last two wrap. One incrementer and one decrementer are shared by all nine operations.

A caller presents an operation code, an operand and a valid strobe. One clock later the block returns a registered result and a matching valid flag. When the strobe is low, the result register keeps its last value. Codes above 8 return zero.

Top module: `trail_mask_unit`

## Requirements
- R1: After a synchronous active-high reset, `res_vld` is 0 and `res` is 0.
- R2: `res` and `res_vld` show the operation on the inputs one clock after `in_vld` is sampled high. `res_vld` is 0 in the clock after `in_vld` is sampled low.
- R3: Code 0 returns x AND (x+1). For example, 0x57 gives 0x50, and 0xFFFFFFFF gives 0.
- R4: Code 1 returns x OR NOT(x+1). For example, 0x50 gives 0xFFFFFFFE, and 0xFF gives 0xFFFFFEFF.
- R5: Code 2 returns NOT x AND (x+1), so the result has at most one bit set. For example, 0x51 gives 0x2, 0xFF gives 0x100, and 0xFFFFFFFF gives 0.
- R6: Code 3 returns x XOR (x+1), so bit 0 of the result is always 1. For example, 0x51 gives 0x3, and 0xFFFFFFFF gives 0xFFFFFFFF.
- R7: Code 4 returns x OR (x+1). For example, 0x51 gives 0x53, and 0xFFFFFFFF gives 0xFFFFFFFF.
- R8: Code 5 returns x OR (x-1). For example, 0x54 gives 0x57, and 0 gives 0xFFFFFFFF.
- R9: Code 6 returns NOT x OR (x-1). For example, 0x54 gives 0xFFFFFFFB, and 0 gives 0xFFFFFFFF.
- R10: Code 7 returns NOT x OR (x+1). For example, 0x57 gives 0xFFFFFFF8, 0 gives 0xFFFFFFFF, and 0xFFFFFFFF gives 0.
- R11: Code 8 returns NOT x AND (x-1), so any odd operand gives 0. For example, 0x58 gives 0x7, 0x59 gives 0, 0 gives 0xFFFFFFFF, and 0x80000000 gives 0x7FFFFFFF.
- R12: Codes 9 to 15 return 0 whatever the operand.
- R13: While `in_vld` is low, `res` keeps its previous value even when `op` and `x` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Marks the inputs as valid |
| op | input | 4 | Operation code, 0 to 8 (9 to 15 give zero) |
| x | input | 32 | Operand |
| res_vld | output | 1 | Result valid, one clock after `in_vld` |
| res | output | 32 | Registered result |

## Verification
Each code is tried with small operands that have a few trailing ones or a few trailing zeros. These show whether the right term and the right gate were chosen. The code is also tried with 0 and 0xFFFFFFFF, where the incrementer or the decrementer wraps. A wrong carry width or a missing wrap shows up only on these two values. The MSB-only operand checks that the borrow travels the full width. Unused codes and an idle strobe are tried with a nonzero operand, so that a result wrongly passed through or wrongly updated becomes visible.

// File: rtl/trail_mask_unit.sv
module trail_mask_unit #(
  parameter int W    = 32,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [SELW-1:0] op,
  input  logic [W-1:0]    x,
  output logic            res_vld,
  output logic [W-1:0]    res
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] inc, dec, nx, nxt;

  assign inc = x + ONE;
  assign dec = x - ONE;
  assign nx  = ~x;

  always_comb begin
    case (op)
      SELW'(0): nxt = x & inc;
      SELW'(1): nxt = x | ~inc;
      SELW'(2): nxt = nx & inc;
      SELW'(3): nxt = x ^ inc;
      SELW'(4): nxt = x | inc;
      SELW'(5): nxt = x | dec;
      SELW'(6): nxt = nx | dec;
      SELW'(7): nxt = nx | inc;
      SELW'(8): nxt = nx & dec;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res     <= '0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) res <= nxt;
    end
  end

endmodule

module trail_mask_unit_chk #(
  parameter int W    = 32,
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            in_vld,
  input logic [SELW-1:0] op,
  input logic [W-1:0]    x,
  input logic            res_vld,
  input logic [W-1:0]    res
);

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_vld);

  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !res_vld);

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(res));

  // R12
  spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op > SELW'(8)) |=> (res == '0));

  // R5
  iso_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op == SELW'(2)) |=> $onehot0(res));

  // R6
  msk_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op == SELW'(3)) |=> res[0]);

  // R11
  tz_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op == SELW'(8) && x[0]) |=> (res == '0));

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!res_vld && res == '0));

endmodule

bind trail_mask_unit trail_mask_unit_chk #(.W(W), .SELW(SELW)) u_chk (.*);

// File: tb/sim_trail_mask_unit.sv
`timescale 1ns/1ps
module sim_trail_mask_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_vld;
  logic [3:0]  op;
  logic [31:0] x;
  logic        res_vld;
  logic [31:0] res;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  trail_mask_unit u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op(op), .x(x),
    .res_vld(res_vld), .res(res)
  );

  localparam int NV = 27;
  // {req, op, operand, expected}
  localparam logic [75:0] VEC [NV] = '{
    {8'd3,  4'd0, 32'h0000_0057, 32'h0000_0050},  // R3
    {8'd3,  4'd0, 32'hFFFF_FFFF, 32'h0000_0000},  // R3
    {8'd4,  4'd1, 32'h0000_0050, 32'hFFFF_FFFE},  // R4
    {8'd4,  4'd1, 32'h0000_00FF, 32'hFFFF_FEFF},  // R4
    {8'd5,  4'd2, 32'h0000_0051, 32'h0000_0002},  // R5
    {8'd5,  4'd2, 32'h0000_00FF, 32'h0000_0100},  // R5
    {8'd5,  4'd2, 32'hFFFF_FFFF, 32'h0000_0000},  // R5
    {8'd6,  4'd3, 32'h0000_0051, 32'h0000_0003},  // R6
    {8'd6,  4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R6
    {8'd7,  4'd4, 32'h0000_0051, 32'h0000_0053},  // R7
    {8'd7,  4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R7
    {8'd8,  4'd5, 32'h0000_0054, 32'h0000_0057},  // R8
    {8'd8,  4'd5, 32'h0000_0000, 32'hFFFF_FFFF},  // R8
    {8'd9,  4'd6, 32'h0000_0054, 32'hFFFF_FFFB},  // R9
    {8'd9,  4'd6, 32'h0000_0000, 32'hFFFF_FFFF},  // R9
    {8'd10, 4'd7, 32'h0000_0057, 32'hFFFF_FFF8},  // R10
    {8'd10, 4'd7, 32'h0000_0000, 32'hFFFF_FFFF},  // R10
    {8'd10, 4'd7, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
    {8'd11, 4'd8, 32'h0000_0058, 32'h0000_0007},  // R11
    {8'd11, 4'd8, 32'h0000_0059, 32'h0000_0000},  // R11
    {8'd11, 4'd8, 32'h0000_0000, 32'hFFFF_FFFF},  // R11
    {8'd11, 4'd8, 32'h8000_0000, 32'h7FFF_FFFF},  // R11
    {8'd12, 4'd9, 32'h1234_5678, 32'h0000_0000},  // R12
    {8'd12, 4'd12, 32'hFFFF_FFFF, 32'h0000_0000}, // R12
    {8'd12, 4'd15, 32'h0000_0055, 32'h0000_0000}, // R12
    {8'd3,  4'd0, 32'h0000_0000, 32'h0000_0000},  // R3
    {8'd7,  4'd4, 32'h0000_0000, 32'h0000_0001}   // R7
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] v);
    @(negedge clk);
    in_vld = 1'b1;
    op     = o;
    x      = v;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; in_vld = 1'b0; op = '0; x = '0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 res_vld", {31'd0, res_vld}, 32'd0);
    check("R1 res", res, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][67:64], VEC[i][63:32]);
      check($sformatf("R%0d op %0d x 0x%08h", VEC[i][75:68], VEC[i][67:64], VEC[i][63:32]),
            res, VEC[i][31:0]);
      check("R2 res_vld high", {31'd0, res_vld}, 32'd1);
    end

    // R2: back-to-back strobes, each result lands one clock later
    apply(4'd3, 32'h0000_0051);
    check("R2 first of pair", res, 32'h0000_0003);
    apply(4'd4, 32'h0000_0051);
    check("R2 second of pair", res, 32'h0000_0053);

    // R13: idle strobe with changing inputs keeps result
    in_vld = 1'b0; op = 4'd7; x = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R2 res_vld low", {31'd0, res_vld}, 32'd0);
    check("R13 hold", res, 32'h0000_0053);
    op = 4'd5; x = 32'h0;
    @(negedge clk);
    check("R13 hold again", res, 32'h0000_0053);

    // R1: reset mid-stream clears state
    apply(4'd6, 32'h0000_0054);
    check("R9 before reset", res, 32'hFFFF_FFFB);
    rst = 1'b1; in_vld = 1'b0;
    @(negedge clk);
    check("R1 res after reset", res, 32'd0);
    check("R1 res_vld after reset", {31'd0, res_vld}, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule